// File: doc/BRIEF.md
# Scan Response Comparator

This block keeps captured scan responses inside the chip. The tail of the scan chain feeds the comparator rather than an output pin. The pin that would have carried the scan output instead carries the expected response into the chip as a serial stream. While the next test vector is shifted in, each bit that leaves the chain is compared with the expected bit that arrives in the same shift cycle. Any difference sets a sticky mismatch flag.

When a full chain length of shift cycles has followed a capture, the block registers a single pass/fail bit for the vector that was captured. Only that bit is visible. Test time and data volume are unchanged: the expected stream uses the cycles that would have unloaded the response. A capture cycle clears the flag and starts a new count. The unload that follows reset has no capture behind it, so it yields no result.

Top module: `scan_resp_cmp`

## Requirements
- R1: During reset and in the first cycle after it, `result_valid` and `result_pass` are both 0.
- R2: Shift cycles made before the first capture after reset never assert `result_valid`, however many of them there are.
- R3: After a capture, once exactly CHAIN_LEN shift cycles have completed with `chain_tail` equal to `exp_bit` in every one, `result_valid` is 1 and `result_pass` is 1 in the cycle after the last shift.
- R4: One inequality between `chain_tail` and `exp_bit` in any one of the CHAIN_LEN shift cycles (the first, a middle or the last) makes `result_pass` 0 when the result becomes valid.
- R5: After a capture and only CHAIN_LEN-1 shift cycles, `result_valid` is still 0.
- R6: A capture makes `result_valid` 0 in the next cycle and clears the mismatch flag, so a mismatch in an earlier vector does not affect the next result.
- R7: A cycle with `shift_en` low is neither counted nor compared, whatever values `chain_tail` and `exp_bit` have.
- R8: Shift cycles after the result becomes valid and before the next capture change neither `result_valid` nor `result_pass`.
- R9: When `capture_en` and `shift_en` are high in the same cycle, the capture takes effect and that cycle is neither counted nor compared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| capture_en | input | 1 | Capture cycle of the scan chain |
| shift_en | input | 1 | Shift cycle of the scan chain |
| chain_tail | input | 1 | Bit leaving the last scan cell |
| exp_bit | input | 1 | Expected response bit from the former scan-out pin |
| result_valid | output | 1 | The pass/fail bit for the last captured vector is ready |
| result_pass | output | 1 | 1 when every unloaded bit matched the expected bit |

## Verification
A table of response and expected-stream pairs runs through the comparator. It includes fully matching streams and streams that differ in only the first, a middle or the last bit, so a flag that samples only some positions shows up as a wrong pass. Further cases check four kinds of timing: idle cycles with conflicting bits placed inside an unload, a capture that coincides with a shift, shifts made after completion, and shifts made before any capture. These separate correct counting and arming from an off-by-one count, a flag that is not cleared, and a result that is exposed too early.

// File: rtl/scmp_pkg.sv
package scmp_pkg;
   typedef enum logic {
      PH_IDLE   = 1'b0,
      PH_UNLOAD = 1'b1
   } scmp_phase_e;
endpackage

// File: rtl/scmp_unload_ctr.sv
module scmp_unload_ctr
   import scmp_pkg::*;
#(
   parameter int CHAIN_LEN = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic capture_en,
   input  logic shift_en,
   output logic cmp_en,
   output logic done
);
   localparam int CNT_W = (CHAIN_LEN > 2) ? $clog2(CHAIN_LEN) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAIN_LEN - 1);

   scmp_phase_e     phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic            step;

   assign step   = (phase_q == PH_UNLOAD) && shift_en && !capture_en;
   assign cmp_en = step;
   assign done   = step && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else if (capture_en) begin
         phase_q <= PH_UNLOAD;
         cnt_q   <= '0;
      end else if (done) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else if (step) begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   // R5: the count never runs past the last position of the chain
   a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

   // R7: an idle cycle leaves the count untouched
   a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_en && !capture_en) |=> $stable(cnt_q));
endmodule

// File: rtl/scmp_sticky.sv
module scmp_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic cmp_en,
   input  logic chain_tail,
   input  logic exp_bit,
   output logic any_miss
);
   logic sticky_q;
   logic bit_miss;

   assign bit_miss = cmp_en && (chain_tail != exp_bit);
   assign any_miss = sticky_q || bit_miss;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sticky_q <= 1'b0;
      else if (clear)  sticky_q <= 1'b0;
      else if (bit_miss) sticky_q <= 1'b1;
   end

   // R6: a capture always leaves the flag cleared
   a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !sticky_q);

   // R7: with comparison disabled the flag cannot newly rise
   a_r7_no_cmp: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmp_en && !clear) |=> $stable(sticky_q));
endmodule

// File: rtl/scmp_result.sv
module scmp_result (
   input  logic clk,
   input  logic rst_n,
   input  logic capture_en,
   input  logic done,
   input  logic any_miss,
   output logic result_valid,
   output logic result_pass
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_valid <= 1'b0;
         result_pass  <= 1'b0;
      end else if (capture_en) begin
         result_valid <= 1'b0;
      end else if (done) begin
         result_valid <= 1'b1;
         result_pass  <= !any_miss;
      end
   end

   // R4: a recorded mismatch at completion yields a fail
   a_r4_fail: assert property (@(posedge clk) disable iff (!rst_n)
      (done && any_miss) |=> (result_valid && !result_pass));

   // R6: a capture withdraws the previous result
   a_r6_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
      capture_en |=> !result_valid);

   // R8: a valid result holds until the next capture
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (result_valid && !capture_en) |=> (result_valid && $stable(result_pass)));
endmodule

// File: rtl/scan_resp_cmp.sv
module scan_resp_cmp #(
   parameter int CHAIN_LEN = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic capture_en,
   input  logic shift_en,
   input  logic chain_tail,
   input  logic exp_bit,
   output logic result_valid,
   output logic result_pass
);
   generate
      if (CHAIN_LEN < 2) begin : g_bad_len
         $error("scan_resp_cmp: CHAIN_LEN must be at least 2");
      end
   endgenerate

   logic cmp_en;
   logic done;
   logic any_miss;

   scmp_unload_ctr #(.CHAIN_LEN(CHAIN_LEN)) u_ctr (
      .clk(clk), .rst_n(rst_n), .capture_en(capture_en), .shift_en(shift_en),
      .cmp_en(cmp_en), .done(done)
   );

   scmp_sticky u_sticky (
      .clk(clk), .rst_n(rst_n), .clear(capture_en), .cmp_en(cmp_en),
      .chain_tail(chain_tail), .exp_bit(exp_bit), .any_miss(any_miss)
   );

   scmp_result u_res (
      .clk(clk), .rst_n(rst_n), .capture_en(capture_en), .done(done),
      .any_miss(any_miss), .result_valid(result_valid), .result_pass(result_pass)
   );

   // R3: completion is only reached from an enabled shift
   a_r3_done_shift: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (shift_en && !capture_en));
endmodule

// File: tb/scan_resp_cmp_bench.sv
module scan_resp_cmp_bench;
   localparam int CLK_PERIOD = 10;
   localparam int LEN = 8;
   localparam int NVEC = 7;
   // {response, expected stream, expected pass}
   localparam logic [16:0] TAB [NVEC] = '{
      {8'hA5, 8'hA5, 1'b1},
      {8'h00, 8'h01, 1'b0},
      {8'h80, 8'h00, 1'b0},
      {8'hFF, 8'hFF, 1'b1},
      {8'h3C, 8'h34, 1'b0},
      {8'h55, 8'hAA, 1'b0},
      {8'h00, 8'h00, 1'b1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic capture_en = 1'b0, shift_en = 1'b0, chain_tail = 1'b0, exp_bit = 1'b0;
   logic result_valid, result_pass;
   int n_chk = 0, n_bad = 0;
   bit done_flag = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   scan_resp_cmp #(.CHAIN_LEN(LEN)) u_scan_resp_cmp (
      .clk(clk), .rst_n(rst_n), .capture_en(capture_en), .shift_en(shift_en),
      .chain_tail(chain_tail), .exp_bit(exp_bit),
      .result_valid(result_valid), .result_pass(result_pass)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   // inputs driven just after a falling edge, held across one rising edge
   task automatic cyc(input logic sh, input logic cap, input logic tl, input logic ex);
      shift_en = sh; capture_en = cap; chain_tail = tl; exp_bit = ex;
      @(negedge clk);
      shift_en = 1'b0; capture_en = 1'b0;
   endtask

   task automatic shift_bits(input logic [7:0] rsp, input logic [7:0] exv, input int n);
      for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, rsp[i], exv[i]);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_flag) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      check("R1 valid in reset", result_valid, 1'b0);
      check("R1 pass in reset", result_pass, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 valid after reset", result_valid, 1'b0);
      check("R1 pass after reset", result_pass, 1'b0);

      // R2: no capture yet, shifting gives no result
      shift_bits(8'h00, 8'h00, LEN);
      shift_bits(8'h00, 8'h00, 3);
      check("R2 no result before capture", result_valid, 1'b0);

      // table walk: R3, R4, R5
      for (int v = 0; v < NVEC; v++) begin
         cyc(1'b0, 1'b1, 1'b0, 1'b0);
         shift_bits(TAB[v][16:9], TAB[v][8:1], LEN - 1);
         check("R5 not valid one shift early", result_valid, 1'b0);
         cyc(1'b1, 1'b0, TAB[v][16], TAB[v][8]);
         check("R3 valid after full unload", result_valid, 1'b1);
         check(TAB[v][0] ? "R3 pass on match" : "R4 fail on mismatch",
               result_pass, TAB[v][0]);
      end

      // R8: extra shifts with mismatches change nothing
      shift_bits(8'hFF, 8'h00, 3);
      check("R8 valid held", result_valid, 1'b1);
      check("R8 pass held", result_pass, 1'b1);

      // R6: failing vector then capture then passing vector
      cyc(1'b0, 1'b1, 1'b0, 1'b0);
      shift_bits(8'h0F, 8'h00, LEN);
      check("R6 setup fail", result_pass, 1'b0);
      cyc(1'b0, 1'b1, 1'b0, 1'b0);
      check("R6 capture clears valid", result_valid, 1'b0);
      shift_bits(8'h5A, 8'h5A, LEN);
      check("R6 flag cleared, pass", result_pass, 1'b1);

      // R7: idle cycles with conflicting bits inside an unload
      cyc(1'b0, 1'b1, 1'b0, 1'b0);
      shift_bits(8'h00, 8'h00, 4);
      for (int k = 0; k < 5; k++) cyc(1'b0, 1'b0, 1'b1, 1'b0);
      check("R7 idle not counted", result_valid, 1'b0);
      shift_bits(8'h00, 8'h00, 3);
      check("R7 idle not counted", result_valid, 1'b0);
      cyc(1'b1, 1'b0, 1'b0, 1'b0);
      check("R7 valid after 8 real shifts", result_valid, 1'b1);
      check("R7 idle not compared", result_pass, 1'b1);

      // R9: capture with shift, conflicting bits in that cycle
      cyc(1'b1, 1'b1, 1'b1, 1'b0);
      shift_bits(8'hC3, 8'hC3, LEN - 1);
      check("R9 concurrent shift not counted", result_valid, 1'b0);
      cyc(1'b1, 1'b0, 1'b1, 1'b1);
      check("R9 valid", result_valid, 1'b1);
      check("R9 concurrent shift not compared", result_pass, 1'b1);

      done_flag = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule